// File: doc/BRIEF.md
# Two-Level Fault Interrupt Aggregator

This block gathers the fault signals of a power-management device into a single active-high interrupt line. It takes one overcurrent signal from a limit switch, four regulator undervoltage signals and five converter undervoltage signals. Each raw signal passes through a two-flop synchronizer. A low-to-high transition of the synchronized signal is then captured in a sticky status bit. A steady high level does not set the bit again.

Every status bit has a mask bit beside it. The status bits that are not masked are ORed into a group interrupt, one for the overcurrent group and one for the undervoltage group. The two group interrupts are ORed into the device interrupt. A host reads and writes four registers through a simple synchronous port. A read returns the word on `reg_rdata` after the next clock edge. Reading a status register clears the events it reports. Masks are ordinary read/write registers.

Top module: `fault_irq_hub`

## Requirements
- R1: A status bit is set only by a low-to-high transition of its synchronized fault input. A fault held high after its status bit was cleared does not set the bit again.
- R2: A read with `reg_rd` high loads `reg_rdata` at that clock edge, and `reg_rdata` holds its value until the next read. A read of a status register (0x1C or 0x1D) clears that register's bits at the same edge.
- R3: If a transition is detected in the same cycle as a clear-on-read of its register, the bit stays set. The read returns the old value and the next read reports the event.
- R4: A mask bit of 1 keeps its status bit out of the group interrupt. A mask bit of 0 lets it through. Each group interrupt (`irq_oc`, `irq_uv`) is the OR of its unmasked status bits.
- R5: A masked status bit still latches and reads back as 1.
- R6: `irq` is high exactly when `irq_oc` or `irq_uv` is high.
- R7: Reset clears every status bit, every mask bit and `reg_rdata`, so all interrupts start unmasked and `irq` is low.
- R8: Bit layout. The overcurrent status is bit 15 of address 0x1D and its mask is bit 15 of address 0x25. The undervoltage status is at 0x1C and its mask is at 0x24. In both, regulator channels 4..1 (`fault_uv_reg[3:0]`) sit at bits 11..8 and converter channels 6..2 (`fault_uv_cnv[4:0]`) sit at bits 5..1.
- R9: Bits outside the R8 layout read as 0 and ignore writes. Writes to status registers have no effect. Any other address reads 0.
- R10: A fault that goes high before clock edge k raises its group interrupt right after edge k+2, that is, after three edges: two synchronizer stages and the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_oc | input | 1 | Raw overcurrent limit-switch fault |
| fault_uv_reg | input | 4 | Raw regulator undervoltage faults, channels 4..1 |
| fault_uv_cnv | input | 5 | Raw converter undervoltage faults, channels 6..2 |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; also triggers clear-on-read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_oc | output | 1 | Overcurrent group interrupt |
| irq_uv | output | 1 | Undervoltage group interrupt |
| irq | output | 1 | Combined interrupt, active high |

## Verification
A status bit that is wrongly set or never cleared shows up on the group interrupt pins in the same cycle, unless it is masked. In every case it shows up on `reg_rdata` one edge after the register is read. A lost or doubled synchronizer stage moves the first interrupt edge by one cycle, so the bench checks the exact edge on which `irq_uv` rises. A reference model runs in step with the design and compares the interrupt outputs and the read data on every clock. A corrupted mask, a clear that came too early, or a dropped event therefore fails within one cycle of the next read or of the interrupt change.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int N_REG    = 4;
    localparam int N_CNV    = 5;
    localparam int N_UV     = N_REG + N_CNV;
    localparam int N_FAULT  = N_UV + 1;
    localparam int SYNC_LEN = 2;

    localparam int OC_BIT   = 15;
    localparam int REG_LSB  = 8;
    localparam int CNV_LSB  = 1;

    localparam logic [ADDR_W-1:0] A_ST_UV = 8'h1C;
    localparam logic [ADDR_W-1:0] A_ST_OC = 8'h1D;
    localparam logic [ADDR_W-1:0] A_MK_UV = 8'h24;
    localparam logic [ADDR_W-1:0] A_MK_OC = 8'h25;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ST_UV,
        SEL_ST_OC,
        SEL_MK_UV,
        SEL_MK_OC
    } reg_sel_e;

    typedef struct packed {
        logic             oc;
        logic [N_REG-1:0] reg_uv;
        logic [N_CNV-1:0] cnv_uv;
    } fault_vec_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            A_ST_UV: s = SEL_ST_UV;
            A_ST_OC: s = SEL_ST_OC;
            A_MK_UV: s = SEL_MK_UV;
            A_MK_OC: s = SEL_MK_OC;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    // uv vector: upper N_REG bits are regulators, lower N_CNV are converters
    function automatic logic [DATA_W-1:0] place_uv(input logic [N_UV-1:0] v);
        logic [DATA_W-1:0] w;
        w = '0;
        w[REG_LSB +: N_REG] = v[N_CNV +: N_REG];
        w[CNV_LSB +: N_CNV] = v[0 +: N_CNV];
        return w;
    endfunction

    function automatic logic [N_UV-1:0] pick_uv(input logic [DATA_W-1:0] w);
        return {w[REG_LSB +: N_REG], w[CNV_LSB +: N_CNV]};
    endfunction

    function automatic logic [DATA_W-1:0] place_oc(input logic b);
        logic [DATA_W-1:0] w;
        w = '0;
        w[OC_BIT] = b;
        return w;
    endfunction

    localparam logic [DATA_W-1:0] LIVE_BITS = place_uv('1) | place_oc(1'b1);

endpackage

// File: rtl/fault_edge_sync.sv
module fault_edge_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] rise
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= '0;
                end else if (s == 0) begin
                    stg[s] <= raw;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= stg[STAGES-1];
    end

    assign rise = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] rise,
    input  logic         rd_clr,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wd,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         grp_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            // a fresh edge wins over the clear so no event is lost
            status <= (rd_clr ? '0 : status) | rise;
            if (mask_we) mask <= mask_wd;
        end
    end

    assign grp_irq = |(status & ~mask);
endmodule

// File: rtl/fault_irq_hub.sv
module fault_irq_hub
    import irqh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fault_oc,
    input  logic [N_REG-1:0]  fault_uv_reg,
    input  logic [N_CNV-1:0]  fault_uv_cnv,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_oc,
    output logic              irq_uv,
    output logic              irq
);
    fault_vec_t        raw_v, rise_v;
    reg_sel_e          sel;
    logic [N_UV-1:0]   uv_rise, uv_status, uv_mask;
    logic              oc_rise, oc_status, oc_mask;
    logic [DATA_W-1:0] rd_word;
    logic              unused_wd;

    assign raw_v = '{oc: fault_oc, reg_uv: fault_uv_reg, cnv_uv: fault_uv_cnv};

    fault_edge_sync #(.W(N_FAULT), .STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  (raw_v),
        .rise (rise_v)
    );

    assign uv_rise = {rise_v.reg_uv, rise_v.cnv_uv};
    assign oc_rise = rise_v.oc;
    assign sel     = decode_addr(reg_addr);

    irq_status_bank #(.W(N_UV)) u_uv (
        .clk     (clk),
        .rst     (rst),
        .rise    (uv_rise),
        .rd_clr  (reg_rd && sel == SEL_ST_UV),
        .mask_we (reg_wr && sel == SEL_MK_UV),
        .mask_wd (pick_uv(reg_wdata)),
        .status  (uv_status),
        .mask    (uv_mask),
        .grp_irq (irq_uv)
    );

    irq_status_bank #(.W(1)) u_oc (
        .clk     (clk),
        .rst     (rst),
        .rise    (oc_rise),
        .rd_clr  (reg_rd && sel == SEL_ST_OC),
        .mask_we (reg_wr && sel == SEL_MK_OC),
        .mask_wd (reg_wdata[OC_BIT]),
        .status  (oc_status),
        .mask    (oc_mask),
        .grp_irq (irq_oc)
    );

    assign irq = irq_oc | irq_uv;

    always_comb begin
        case (sel)
            SEL_ST_UV: rd_word = place_uv(uv_status);
            SEL_ST_OC: rd_word = place_oc(oc_status);
            SEL_MK_UV: rd_word = place_uv(uv_mask);
            SEL_MK_OC: rd_word = place_oc(oc_mask);
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    assign unused_wd = ^(reg_wdata & ~LIVE_BITS);
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irqh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_oc,
    input logic              irq_uv,
    input logic [N_UV-1:0]   uv_rise,
    input logic [N_UV-1:0]   uv_status,
    input logic [N_UV-1:0]   uv_mask,
    input logic              oc_rise,
    input logic              oc_status,
    input logic              oc_mask
);
    // R1
    sts_set_by_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ((uv_status & ~$past(uv_status) & ~$past(uv_rise)) == '0) &&
        !(oc_status && !$past(oc_status) && !$past(oc_rise)));

    // R2
    rd_clears_uv_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_ST_UV) |=> ((uv_status & ~$past(uv_rise)) == '0));

    // R2
    rd_clears_oc_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == A_ST_OC && !oc_rise) |=> !oc_status);

    // R3
    edge_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (|uv_rise) |=> ((uv_status & $past(uv_rise)) == $past(uv_rise)));

    // R4
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((&uv_mask) |-> !irq_uv) and (oc_mask |-> !irq_oc));

    // R7
    mask_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (uv_mask == '0 && !oc_mask));

    // R9
    dead_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~LIVE_BITS) == '0);
endmodule

bind fault_irq_hub irq_hub_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .irq_oc    (irq_oc),
    .irq_uv    (irq_uv),
    .uv_rise   (uv_rise),
    .uv_status (uv_status),
    .uv_mask   (uv_mask),
    .oc_rise   (oc_rise),
    .oc_status (oc_status),
    .oc_mask   (oc_mask)
);

// File: tb/fault_irq_hub_test.sv
module fault_irq_hub_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fault_oc = 1'b0;
    logic [3:0]  fault_uv_reg = '0;
    logic [4:0]  fault_uv_cnv = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_oc, irq_uv, irq;

    int checks = 0;
    int errs   = 0;
    int cyc    = 0;
    bit done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    fault_irq_hub uut (
        .clk(clk), .rst(rst), .fault_oc(fault_oc), .fault_uv_reg(fault_uv_reg),
        .fault_uv_cnv(fault_uv_cnv), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_oc(irq_oc), .irq_uv(irq_uv), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit [9:0]  hist[$];
    bit [8:0]  m_uvs, m_uvm;
    bit        m_ocs, m_ocm;
    bit [15:0] m_rdata;

    function automatic bit [15:0] m_word(input bit [7:0] a);
        case (a)
            8'h1C:   return {4'b0, m_uvs[8:5], 2'b0, m_uvs[4:0], 1'b0};
            8'h1D:   return {m_ocs, 15'b0};
            8'h24:   return {4'b0, m_uvm[8:5], 2'b0, m_uvm[4:0], 1'b0};
            8'h25:   return {m_ocm, 15'b0};
            default: return 16'h0;
        endcase
    endfunction

    initial hist = '{10'h0, 10'h0, 10'h0};

    always @(posedge clk) begin
        bit [9:0] rise;
        if (rst) begin
            m_uvs = '0; m_uvm = '0; m_ocs = 0; m_ocm = 0; m_rdata = '0;
            hist = '{10'h0, 10'h0, 10'h0};
        end else begin
            rise = hist[1] & ~hist[2];
            if (reg_rd) m_rdata = m_word(reg_addr);
            if (reg_rd && reg_addr == 8'h1C) m_uvs = '0;
            if (reg_rd && reg_addr == 8'h1D) m_ocs = 0;
            m_uvs = m_uvs | rise[8:0];
            m_ocs = m_ocs | rise[9];
            if (reg_wr && reg_addr == 8'h24) m_uvm = {reg_wdata[11:8], reg_wdata[5:1]};
            if (reg_wr && reg_addr == 8'h25) m_ocm = reg_wdata[15];
            hist.push_front({fault_oc, fault_uv_reg, fault_uv_cnv});
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R2 model rdata", reg_rdata, m_rdata);
            check("R4 model irq_uv", {15'b0, irq_uv}, {15'b0, |(m_uvs & ~m_uvm)});
            check("R4 model irq_oc", {15'b0, irq_oc}, {15'b0, m_ocs & ~m_ocm});
            check("R6 model irq", {15'b0, irq},
                  {15'b0, (|(m_uvs & ~m_uvm)) | (m_ocs & ~m_ocm)});
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input bit [7:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input bit [7:0] a, input bit [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [15:0] d;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R7 reset state
        check("R7 irq after reset", {15'b0, irq}, 16'h0);
        check("R7 rdata after reset", reg_rdata, 16'h0);
        rd(8'h24, d); check("R7 uv mask reset", d, 16'h0);
        rd(8'h25, d); check("R7 oc mask reset", d, 16'h0);

        // R10 latency, regulator ch1 -> bit 8
        fault_uv_reg[0] = 1'b1;
        tick(); check("R10 after 1 edge", {15'b0, irq_uv}, 16'h0);
        tick(); check("R10 after 2 edges", {15'b0, irq_uv}, 16'h0);
        tick(); check("R10 after 3 edges", {15'b0, irq_uv}, 16'h1);
        check("R6 irq follows uv", {15'b0, irq}, 16'h1);
        rd(8'h1C, d); check("R8 reg ch1 at bit 8", d, 16'h0100);
        rd(8'h1C, d); check("R2 cleared by read", d, 16'h0);
        repeat (3) tick();
        rd(8'h1C, d); check("R1 held level no retrigger", d, 16'h0);
        check("R1 irq stays low", {15'b0, irq}, 16'h0);

        // R4/R5 masking, R9 mask unused bits
        wr(8'h24, 16'hFFFF);
        rd(8'h24, d); check("R9 uv mask live bits only", d, 16'h0F3E);
        fault_uv_cnv[4] = 1'b1;
        repeat (4) tick();
        check("R4 masked no irq_uv", {15'b0, irq_uv}, 16'h0);
        check("R4 masked no irq", {15'b0, irq}, 16'h0);
        rd(8'h1C, d); check("R5 masked cnv ch6 bit 5 latched", d, 16'h0020);

        // R9 status write ignored, unknown address
        fault_uv_cnv[3] = 1'b1;
        repeat (4) tick();
        wr(8'h1C, 16'h0000);
        rd(8'h1C, d); check("R9 status write ignored", d, 16'h0010);
        rd(8'h30, d); check("R9 unknown address", d, 16'h0);

        // overcurrent group
        wr(8'h24, 16'h0000);
        fault_oc = 1'b1;
        repeat (4) tick();
        check("R4 oc unmasked irq_oc", {15'b0, irq_oc}, 16'h1);
        check("R6 irq from oc", {15'b0, irq}, 16'h1);
        rd(8'h1D, d); check("R8 oc at bit 15", d, 16'h8000);
        check("R2 irq drops after read", {15'b0, irq}, 16'h0);
        wr(8'h25, 16'hFFFF);
        rd(8'h25, d); check("R8 oc mask bit 15", d, 16'h8000);

        // R3 edge in the same cycle as a clear-on-read; converter ch2 -> bit 1
        rd(8'h1C, d);
        fault_uv_cnv[0] = 1'b1;
        tick(); tick();
        rd(8'h1C, d); check("R3 read returns old value", d, 16'h0);
        check("R3 irq_uv held", {15'b0, irq_uv}, 16'h1);
        rd(8'h1C, d); check("R3 event kept", d, 16'h0002);

        tick();
        finish_run();
    end
endmodule